// File: doc/BRIEF.md
# Compare-to-Bitmask Unit with Bit-Test Branch

This block takes two register operands and produces, in a single operation, a word in which every relation between them is its own bit. Signed and unsigned ordering, equality and inequality are all present at once, so a later instruction can pick whichever relation it needs. No dedicated flags register is involved: the result is an ordinary data word that can be stored in a general register.

Beside the compare logic sits a branch resolver. It takes any register value, a bit index and a polarity. It branches when the indexed bit matches the polarity, either set or clear. It also takes the current PC and a target, and produces the next PC together with a taken flag. A typical use is to compare two values and then branch on one bit of the resulting word.

Top module: `cmp_bitbranch`

## Requirements
- R1: While reset is asserted and after its release, `cmp_word`, `cmp_ready`, `br_valid`, `br_taken` and `next_pc` are all zero until the first strobe.
- R2: Bit 0 of the result is set when the operands are equal, and bit 1 is set when they differ.
- R3: Two's-complement relations of a to b are held in bits 2 (less), 3 (less-or-equal), 4 (greater) and 5 (greater-or-equal).
- R4: Unsigned relations of a to b are held in bits 6 (less), 7 (less-or-equal), 8 (greater) and 9 (greater-or-equal).
- R5: Bits 31 down to 10 of the result are always zero, so a bit-test on any of them reads zero.
- R6: The result word appears on the clock edge that samples `cmp_go`, with `cmp_ready` high for exactly that one cycle. Without a strobe the word holds its value.
- R7: A branch is taken when the indexed bit of `br_src` equals `br_when_set`: a value of 1 branches on a set bit and a value of 0 branches on a clear bit.
- R8: On a taken branch, `next_pc` is `br_target` with its two low bits forced to zero.
- R9: On a branch that is not taken, `next_pc` is `br_pc + 4`, wrapping modulo 2^32.
- R10: `br_valid` is high for exactly the one cycle after the edge that samples `br_go`. Without a strobe, `next_pc` and `br_taken` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmp_go | input | 1 | Compare strobe |
| cmp_a | input | 32 | First operand |
| cmp_b | input | 32 | Second operand |
| cmp_word | output | 32 | Relation bitmask |
| cmp_ready | output | 1 | Result-valid pulse |
| br_go | input | 1 | Branch strobe |
| br_src | input | 32 | Register value that is tested |
| br_idx | input | 5 | Index of the tested bit |
| br_when_set | input | 1 | Polarity: 1 branches on set, 0 branches on clear |
| br_pc | input | 32 | PC of the branch |
| br_target | input | 32 | Branch destination |
| br_valid | output | 1 | Decision-valid pulse |
| br_taken | output | 1 | Branch taken |
| next_pc | output | 32 | Resolved next PC |

## Verification
Both the compare result and the branch decision are due one clock edge after their strobe. Each test task raises the strobe on a falling edge and removes it on the next falling edge. It then samples the outputs at that falling edge, which lies half a period after the capturing rising edge. Each task waits one more falling edge and checks that the valid pulse has dropped while the results keep their values. The corner cases covered are operands that differ only in the sign bit, unsigned wrap of the fall-through PC, and bit-tests on the unused upper bits of a compare word.

// File: rtl/cmp_bitbranch.sv
module cmp_bitbranch #(
  parameter int W    = 32,
  parameter int AW   = 32,
  parameter int ILEN = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmp_go,
  input  logic [W-1:0]         cmp_a,
  input  logic [W-1:0]         cmp_b,
  output logic [W-1:0]         cmp_word,
  output logic                 cmp_ready,
  input  logic                 br_go,
  input  logic [W-1:0]         br_src,
  input  logic [$clog2(W)-1:0] br_idx,
  input  logic                 br_when_set,
  input  logic [AW-1:0]        br_pc,
  input  logic [AW-1:0]        br_target,
  output logic                 br_valid,
  output logic                 br_taken,
  output logic [AW-1:0]        next_pc
);
  localparam int NREL = 10;

  logic          eq, slt, ult;
  logic [W-1:0]  rel;
  logic          hit;
  logic [AW-1:0] fall_pc, jump_pc;

  assign eq  = (cmp_a == cmp_b);
  assign slt = ($signed(cmp_a) < $signed(cmp_b));
  assign ult = (cmp_a < cmp_b);

  always_comb begin
    rel    = '0;
    rel[0] = eq;
    rel[1] = !eq;
    rel[2] = slt;
    rel[3] = slt || eq;
    rel[4] = !slt && !eq;
    rel[5] = !slt;
    rel[6] = ult;
    rel[7] = ult || eq;
    rel[8] = !ult && !eq;
    rel[9] = !ult;
  end

  assign hit     = (br_src[br_idx] == br_when_set);
  assign fall_pc = br_pc + AW'(ILEN);
  assign jump_pc = {br_target[AW-1:2], 2'b00};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_word  <= '0;
      cmp_ready <= 1'b0;
    end else begin
      cmp_ready <= cmp_go;
      if (cmp_go) cmp_word <= rel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      br_valid <= 1'b0;
      br_taken <= 1'b0;
      next_pc  <= '0;
    end else begin
      br_valid <= br_go;
      if (br_go) begin
        br_taken <= hit;
        next_pc  <= hit ? jump_pc : fall_pc;
      end
    end
  end

  if (W < NREL) begin : g_width_check
    initial $error("cmp_bitbranch: W must be at least %0d", NREL);
  end
endmodule

// File: rtl/cmp_bitbranch_chk.sv
module cmp_bitbranch_chk #(
  parameter int W  = 32,
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmp_go,
  input logic [W-1:0]  cmp_word,
  input logic          cmp_ready,
  input logic          br_go,
  input logic          br_valid,
  input logic          br_taken,
  input logic [AW-1:0] next_pc
);
  a_r5_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_word[W-1:10] == '0);

  a_r2_eq_ne_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_go |=> (cmp_word[0] != cmp_word[1]));

  a_r3_signed_lt_ge: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_go |=> (cmp_word[2] != cmp_word[5]) && (cmp_word[3] != cmp_word[4]));

  a_r4_unsigned_lt_ge: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_go |=> (cmp_word[6] != cmp_word[9]) && (cmp_word[7] != cmp_word[8]));

  a_r6_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_go |=> cmp_ready);

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_go |=> !cmp_ready && $stable(cmp_word));

  a_r10_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    br_go |=> br_valid);

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !br_go |=> !br_valid && $stable(next_pc) && $stable(br_taken));

  a_r8_aligned_target: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && br_taken) |-> (next_pc[1:0] == 2'b00));
endmodule

bind cmp_bitbranch cmp_bitbranch_chk #(.W(W), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmp_go(cmp_go), .cmp_word(cmp_word),
  .cmp_ready(cmp_ready), .br_go(br_go), .br_valid(br_valid),
  .br_taken(br_taken), .next_pc(next_pc)
);

// File: tb/sim_cmp_bitbranch.sv
module sim_cmp_bitbranch;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmp_go = 1'b0;
  logic [31:0] cmp_a = '0, cmp_b = '0;
  logic [31:0] cmp_word;
  logic        cmp_ready;
  logic        br_go = 1'b0;
  logic [31:0] br_src = '0;
  logic [4:0]  br_idx = '0;
  logic        br_when_set = 1'b0;
  logic [31:0] br_pc = '0, br_target = '0;
  logic        br_valid, br_taken;
  logic [31:0] next_pc;

  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  cmp_bitbranch u0 (
    .clk(clk), .rst_n(rst_n), .cmp_go(cmp_go), .cmp_a(cmp_a), .cmp_b(cmp_b),
    .cmp_word(cmp_word), .cmp_ready(cmp_ready), .br_go(br_go), .br_src(br_src),
    .br_idx(br_idx), .br_when_set(br_when_set), .br_pc(br_pc),
    .br_target(br_target), .br_valid(br_valid), .br_taken(br_taken),
    .next_pc(next_pc)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model(input logic [31:0] a, input logic [31:0] b);
    logic [31:0] m = '0;
    logic signed [31:0] sa = a;
    logic signed [31:0] sb = b;
    m[0] = (a == b);   m[1] = (a != b);
    m[2] = (sa < sb);  m[3] = (sa <= sb); m[4] = (sa > sb); m[5] = (sa >= sb);
    m[6] = (a < b);    m[7] = (a <= b);   m[8] = (a > b);   m[9] = (a >= b);
    return m;
  endfunction

  task automatic t_cmp(input logic [31:0] a, input logic [31:0] b);
    logic [31:0] e;
    logic [31:0] held;
    e = model(a, b);
    @(negedge clk);
    cmp_a = a; cmp_b = b; cmp_go = 1'b1;
    @(negedge clk);
    cmp_go = 1'b0;
    chk("R6 ready pulse", {31'b0, cmp_ready}, 32'd1);
    chk("R2 eq/ne bits", {30'b0, cmp_word[1:0]}, {30'b0, e[1:0]});
    chk("R3 signed bits", {28'b0, cmp_word[5:2]}, {28'b0, e[5:2]});
    chk("R4 unsigned bits", {28'b0, cmp_word[9:6]}, {28'b0, e[9:6]});
    chk("R5 upper bits zero", {10'b0, cmp_word[31:10]}, 32'd0);
    held = cmp_word;
    cmp_a = ~a; cmp_b = b ^ 32'h5;
    @(negedge clk);
    chk("R6 ready dropped", {31'b0, cmp_ready}, 32'd0);
    chk("R6 word held", cmp_word, held);
  endtask

  task automatic t_br(input logic [31:0] src, input logic [4:0] idx, input logic pol,
                      input logic [31:0] pc, input logic [31:0] tgt, input logic exp_t);
    logic [31:0] e;
    e = exp_t ? {tgt[31:2], 2'b00} : pc + 32'd4;
    @(negedge clk);
    br_src = src; br_idx = idx; br_when_set = pol; br_pc = pc; br_target = tgt;
    br_go = 1'b1;
    @(negedge clk);
    br_go = 1'b0;
    chk("R10 valid pulse", {31'b0, br_valid}, 32'd1);
    chk("R7 taken", {31'b0, br_taken}, {31'b0, exp_t});
    if (exp_t) chk("R8 target aligned", next_pc, e);
    else       chk("R9 fall through", next_pc, e);
    br_pc = pc + 32'h100; br_target = tgt ^ 32'hF0; br_when_set = ~pol;
    @(negedge clk);
    chk("R10 valid dropped", {31'b0, br_valid}, 32'd0);
    chk("R10 next_pc held", next_pc, e);
    chk("R10 taken held", {31'b0, br_taken}, {31'b0, exp_t});
  endtask

  initial begin
    logic [31:0] w;
    repeat (2) @(negedge clk);
    chk("R1 reset word", cmp_word, 32'd0);
    chk("R1 reset next_pc", next_pc, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", {29'b0, cmp_ready, br_valid, br_taken}, 32'd0);
    chk("R1 word after release", cmp_word, 32'd0);

    t_cmp(32'd5, 32'd5);
    t_cmp(32'd3, 32'd9);
    t_cmp(32'd9, 32'd3);
    t_cmp(32'hFFFF_FFFF, 32'd1);
    t_cmp(32'd1, 32'hFFFF_FFFF);
    t_cmp(32'h8000_0000, 32'h7FFF_FFFF);
    t_cmp(32'h8000_0000, 32'h0000_0000);
    t_cmp(32'd0, 32'd0);

    t_cmp(32'd2, 32'd7);
    w = model(32'd2, 32'd7);
    t_br(w, 5'd2, 1'b1, 32'h0000_1000, 32'h0000_2003, w[2]);
    t_br(w, 5'd0, 1'b0, 32'h0000_1000, 32'h0000_3002, 1'b1);
    t_br(w, 5'd0, 1'b1, 32'h0000_1000, 32'h0000_3000, 1'b0);
    t_br(w, 5'd20, 1'b1, 32'h0000_4000, 32'h0000_5000, 1'b0);
    t_br(w, 5'd31, 1'b0, 32'h0000_4000, 32'h0000_5001, 1'b1);
    t_br(32'h8000_0000, 5'd31, 1'b1, 32'h0000_0040, 32'hFFFF_FFFF, 1'b1);
    t_br(32'h8000_0000, 5'd31, 1'b0, 32'hFFFF_FFFC, 32'h0000_0100, 1'b0);
    t_br(32'h0000_0000, 5'd7, 1'b0, 32'h0000_0010, 32'h0000_0020, 1'b1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule